// File: doc/BRIEF.md
# PHY Address Discovery Sequencer

This block finds the first Ethernet PHY on a management bus after reset, without software. A one-cycle start pulse launches a scan that reads the first identifier register (register 2) at every management address. It goes upward from address 0 and stops at the first address that returns something other than all ones. It then reads the second identifier register (register 3) at that address. The result is the address and a 32-bit identifier, with register 2 in the upper half. A mask removes the 4-bit revision field, so the remaining model code can be compared directly.

A PHY that is still leaving its own reset answers with all ones. The block therefore repeats the full scan after a fixed wait, up to a parameterised number of passes. If every pass comes up empty, it reports an invalid address. The bus itself is driven by a separate MDIO master. This block talks to that master through a request / completion / acknowledge handshake and runs only one transaction at a time.

Top module: `phy_probe_seq`

## Requirements
- R1: A start pulse begins a pass at address 0. Register-2 reads go to addresses 0, 1, 2, ... in strict ascending order, one read per address, and the scan stops at the first address that answers.
- R2: A register-2 response of 16'hFFFF means no PHY is at that address. Any other value is a hit.
- R3: On a hit, register 3 is read at the same address. `phy_id` becomes {register-2 data, register-3 data}. `phy_addr` becomes {1'b0, hit address}.
- R4: At most MAX_PASSES passes are made. On a hit, `pass_count` holds the number of the pass (counting from 1) in which the hit happened.
- R5: If every pass finds nothing, the block ends with `done`=1, `found`=0, `phy_addr`=6'h3F and `pass_count`=MAX_PASSES.
- R6: Before every pass except the first, the block waits CLK_HZ/1e6*WAIT_US clock cycles and issues no request during that time. The first pass starts without this wait.
- R7: `model_id` equals `phy_id` with bits [3:0] forced to zero.
- R8: Handshake rules:
  - `cmd_req` rises only while `cmd_done` is low.
  - `cmd_req` stays high until `cmd_done` is seen.
  - `cmd_ack` pulses for one cycle after `cmd_done` is seen.
  - No new request starts before `cmd_done` has fallen.
- R9: `done` stays high with stable results until the next start. A start that arrives while a discovery is running is ignored.
- R10: After reset, the block shows:
  - `done`=0, `found`=0
  - `phy_addr`=6'h3F
  - `phy_id`=0
  - `pass_count`=0
  - `cmd_req`=0, `cmd_ack`=0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches discovery |
| cmd_req | output | 1 | Read request to the MDIO master |
| cmd_phy | output | 5 | Management address of the request |
| cmd_reg | output | 5 | Register number of the request |
| cmd_done | input | 1 | Completion flag from the master, held until acknowledged |
| cmd_rdata | input | 16 | Read data, valid while cmd_done is high |
| cmd_ack | output | 1 | One-cycle acknowledge of a completion |
| done | output | 1 | Discovery finished |
| found | output | 1 | A PHY was found |
| phy_addr | output | 6 | Found address, 6'h3F when none |
| phy_id | output | 32 | Combined identifier |
| model_id | output | 32 | Identifier with revision bits cleared |
| pass_count | output | PASS_W | Pass number of the hit or of the last pass |

## Verification
The bench sweeps every PHY address from 0 to 31. Each address is paired with a wake-up pass that ranges from the first pass to one beyond the limit, so hits on early, middle and last passes are all covered, along with total failure. A design that checked the pass limit off by one would report the wrong pass count, or would give up one pass too early or too late. A design that skipped or repeated addresses, or resumed a scan from the hit address instead of 0, would break the ascending-order check. Further runs place two PHYs on the bus to confirm the lower address wins, and measure the gap between passes against the programmed wait. They also fire a second start in the middle of a scan, which a design that restarted would answer with an earlier pass count. The handshake model flags any request raised while the completion flag is still up.

// File: rtl/phy_probe_pkg.sv
// Shared constants and types for the PHY discovery sequencer.
package phy_probe_pkg;
    localparam int ADDR_W  = 5;
    localparam int REG_W   = 5;
    localparam int DATA_W  = 16;
    localparam logic [DATA_W-1:0] ABSENT_VAL = 16'hFFFF;
    localparam logic [ADDR_W-1:0] ADDR_LAST  = 5'd31;
    localparam logic [ADDR_W:0]   ADDR_NONE  = 6'h3F;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_WAIT = 3'd1,
        SQ_SCAN = 3'd2,
        SQ_ID2  = 3'd3,
        SQ_DONE = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_REQ   = 2'd1,
        HS_ACK   = 2'd2,
        HS_DRAIN = 2'd3
    } hs_state_t;
endpackage

// File: rtl/phy_probe_delay.sv
// Inter-pass wait timer.
// A load pulse arms the timer. Exactly WAIT_CYC clock edges later it emits a
// one-cycle expired pulse. Assumes WAIT_CYC >= 1 and that load is not
// repeated while the timer is running.
module phy_probe_delay #(
    parameter int WAIT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic             run;

    // Count down from WAIT_CYC and flag the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            run     <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (load) begin
                cnt <= CNT_W'(WAIT_CYC);
                run <= 1'b1;
            end else if (run) begin
                if (cnt == CNT_W'(1)) begin
                    run     <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R6: an expiry always ends a running count and is never back-to-back.
    a_r6_single_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
endmodule

// File: rtl/phy_probe_mdio_if.sv
// Handshake front end toward an MDIO master.
// A go pulse accepted in idle raises cmd_req with the latched address and
// register. The request is held until cmd_done, then the data is captured and
// a one-cycle cmd_ack is sent. Once cmd_done has fallen, rsp_valid pulses.
// Assumes the master holds cmd_done until it sees cmd_ack, then drops it.
module phy_probe_mdio_if
    import phy_probe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_phy,
    input  logic [REG_W-1:0]  go_reg,
    output logic              cmd_req,
    output logic [ADDR_W-1:0] cmd_phy,
    output logic [REG_W-1:0]  cmd_reg,
    input  logic              cmd_done,
    input  logic [DATA_W-1:0] cmd_rdata,
    output logic              cmd_ack,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    hs_state_t hs;

    // Walk one transaction through request, acknowledge and drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs        <= HS_IDLE;
            cmd_req   <= 1'b0;
            cmd_phy   <= '0;
            cmd_reg   <= '0;
            cmd_ack   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            cmd_ack   <= 1'b0;
            unique case (hs)
                HS_IDLE: begin
                    if (go && !cmd_done) begin
                        cmd_req <= 1'b1;
                        cmd_phy <= go_phy;
                        cmd_reg <= go_reg;
                        hs      <= HS_REQ;
                    end
                end
                HS_REQ: begin
                    if (cmd_done) begin
                        rsp_data <= cmd_rdata;
                        cmd_req  <= 1'b0;
                        cmd_ack  <= 1'b1;
                        hs       <= HS_ACK;
                    end
                end
                HS_ACK: begin
                    hs <= HS_DRAIN;
                end
                HS_DRAIN: begin
                    if (!cmd_done) begin
                        rsp_valid <= 1'b1;
                        hs        <= HS_IDLE;
                    end
                end
                default: hs <= HS_IDLE;
            endcase
        end
    end

    // R8: a new request only while the completion flag is clear.
    a_r8_req_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_req) |-> !$past(cmd_done));
    // R8: acknowledge only follows an observed completion.
    a_r8_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ack) |-> $past(cmd_done));
    // R8: request is held until completion arrives.
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_done) |=> cmd_req);
    // R8: address and register stay stable while requested.
    a_r8_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && $past(cmd_req)) |-> ($stable(cmd_phy) && $stable(cmd_reg)));
endmodule

// File: rtl/phy_probe_seq.sv
// PHY address discovery sequencer (top).
// A start pulse launches ascending scans of management addresses 0..31. Each
// scan reads the first identifier register and stops at the first response
// other than all ones, then reads the second identifier register. Empty
// scans are repeated after a fixed wait, up to MAX_PASSES times. Results are
// held with done until the next start; a start during a run is ignored.
// Assumes the MDIO master follows the handshake of phy_probe_mdio_if.
module phy_probe_seq
    import phy_probe_pkg::*;
#(
    parameter int          CLK_HZ     = 100_000_000,
    parameter int          WAIT_US    = 10_000,
    parameter int          MAX_PASSES = 11,
    parameter int          REV_W      = 4,
    parameter logic [4:0]  ID1_REG    = 5'd2,
    parameter logic [4:0]  ID2_REG    = 5'd3,
    localparam int         PASS_W     = $clog2(MAX_PASSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cmd_req,
    output logic [4:0]        cmd_phy,
    output logic [4:0]        cmd_reg,
    input  logic              cmd_done,
    input  logic [15:0]       cmd_rdata,
    output logic              cmd_ack,
    output logic              done,
    output logic              found,
    output logic [5:0]        phy_addr,
    output logic [31:0]       phy_id,
    output logic [31:0]       model_id,
    output logic [PASS_W-1:0] pass_count
);
    localparam int WAIT_CYC_RAW = (CLK_HZ / 1_000_000) * WAIT_US;
    localparam int WAIT_CYC     = (WAIT_CYC_RAW < 1) ? 1 : WAIT_CYC_RAW;
    localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(MAX_PASSES);

    seq_state_t        st;
    logic [ADDR_W-1:0] scan_addr;
    logic              go;
    logic              tmr_load;
    logic              tmr_exp;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [REG_W-1:0]  go_reg;
    logic              busy;

    assign busy   = (st != SQ_IDLE) && (st != SQ_DONE);
    assign go_reg = (st == SQ_ID2) ? ID2_REG : ID1_REG;

    phy_probe_mdio_if u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_phy    (scan_addr),
        .go_reg    (go_reg),
        .cmd_req   (cmd_req),
        .cmd_phy   (cmd_phy),
        .cmd_reg   (cmd_reg),
        .cmd_done  (cmd_done),
        .cmd_rdata (cmd_rdata),
        .cmd_ack   (cmd_ack),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    phy_probe_delay #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_exp)
    );

    // Main discovery sequence: scan, wait between passes, read ID, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= SQ_IDLE;
            scan_addr  <= '0;
            go         <= 1'b0;
            tmr_load   <= 1'b0;
            done       <= 1'b0;
            found      <= 1'b0;
            phy_addr   <= ADDR_NONE;
            phy_id     <= '0;
            pass_count <= '0;
        end else begin
            go       <= 1'b0;
            tmr_load <= 1'b0;
            unique case (st)
                SQ_IDLE, SQ_DONE: begin
                    if (start) begin
                        done       <= 1'b0;
                        found      <= 1'b0;
                        phy_addr   <= ADDR_NONE;
                        phy_id     <= '0;
                        pass_count <= PASS_W'(1);
                        scan_addr  <= '0;
                        go         <= 1'b1;
                        st         <= SQ_SCAN;
                    end
                end
                SQ_WAIT: begin
                    if (tmr_exp) begin
                        go <= 1'b1;
                        st <= SQ_SCAN;
                    end
                end
                SQ_SCAN: begin
                    if (rsp_valid) begin
                        if (rsp_data != ABSENT_VAL) begin
                            phy_id[31:16] <= rsp_data;
                            go            <= 1'b1;
                            st            <= SQ_ID2;
                        end else if (scan_addr == ADDR_LAST) begin
                            if (pass_count == PASS_LAST) begin
                                done     <= 1'b1;
                                phy_addr <= ADDR_NONE;
                                st       <= SQ_DONE;
                            end else begin
                                pass_count <= pass_count + 1'b1;
                                scan_addr  <= '0;
                                tmr_load   <= 1'b1;
                                st         <= SQ_WAIT;
                            end
                        end else begin
                            scan_addr <= scan_addr + 1'b1;
                            go        <= 1'b1;
                        end
                    end
                end
                SQ_ID2: begin
                    if (rsp_valid) begin
                        phy_id[15:0] <= rsp_data;
                        phy_addr     <= {1'b0, scan_addr};
                        found        <= 1'b1;
                        done         <= 1'b1;
                        st           <= SQ_DONE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Revision field removed for model comparison.
    generate
        if (REV_W > 0) begin : g_mask
            assign model_id = {phy_id[31:REV_W], {REV_W{1'b0}}};
        end else begin : g_nomask
            assign model_id = phy_id;
        end
    endgenerate

    // R1: a miss below the last address advances the scan by exactly one.
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_SCAN && rsp_valid && rsp_data == ABSENT_VAL && scan_addr != ADDR_LAST)
        |=> (scan_addr == $past(scan_addr) + 1'b1));
    // R3: the second ID read stays on the hit address.
    a_r3_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_reg == ID2_REG) |-> (cmd_phy == scan_addr));
    // R4: the pass counter never runs past the limit.
    a_r4_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pass_count <= PASS_LAST);
    // R5: a failed discovery reports the invalid address.
    a_r5_fail_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (phy_addr == ADDR_NONE));
    // R6: no request is issued while waiting between passes.
    a_r6_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_WAIT) |-> !cmd_req);
    // R9: done holds until a start arrives.
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(phy_addr) && $stable(phy_id)));
    // R9: a start while busy does not rewind the pass counter.
    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && st != SQ_SCAN) |=> (pass_count == $past(pass_count)));
endmodule

// File: tb/phy_probe_seq_bench.sv
module phy_probe_seq_bench;
    localparam int CLK_HZ = 1_000_000;
    localparam int WAIT_US = 20;
    localparam int WAIT_CYC = 20;
    localparam int MAXP = 3;
    localparam int PW = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmd_req, cmd_ack, cmd_done;
    logic [4:0] cmd_phy, cmd_reg;
    logic [15:0] cmd_rdata;
    logic done, found;
    logic [5:0] phy_addr;
    logic [31:0] phy_id, model_id;
    logic [PW-1:0] pass_count;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Bus model state
    int ph_a = 0, ph_b = -1, wake = 1;
    int passno = 0, exp_next = 0, order_err = 0, reg_err = 0, hs_err = 0;
    int last_end = 0, gap_min = 1 << 30, gap_max = 0, lat = 0;
    logic m_done = 1'b0;
    logic [15:0] m_data = '0;
    logic prev_req = 1'b0;
    logic [4:0] hit_seen = '0;

    assign cmd_done  = m_done;
    assign cmd_rdata = m_data;

    phy_probe_seq #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US), .MAX_PASSES(MAXP)) u_phy_probe_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_req(cmd_req), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
        .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .cmd_ack(cmd_ack),
        .done(done), .found(found), .phy_addr(phy_addr), .phy_id(phy_id),
        .model_id(model_id), .pass_count(pass_count)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] id1_of(int a);
        return 16'h0100 + 16'(a);
    endfunction
    function automatic logic [15:0] id2_of(int a);
        return 16'hA5C0 + 16'(a * 3);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // MDIO master model, acting at the falling edge.
    initial forever begin
        @(negedge clk);
        cyc++;
        if (cmd_req && !prev_req && m_done) hs_err++;
        if (cmd_req && !prev_req && cmd_reg == 5'd2) begin
            if (cmd_phy == 5'd0) begin
                passno++;
                if (passno > 1) begin
                    if (cyc - last_end < gap_min) gap_min = cyc - last_end;
                    if (cyc - last_end > gap_max) gap_max = cyc - last_end;
                end
                exp_next = 0;
            end
            if (int'(cmd_phy) != exp_next) order_err++;
            exp_next = int'(cmd_phy) + 1;
        end
        if (cmd_req && !prev_req && cmd_reg == 5'd3 && cmd_phy != hit_seen) reg_err++;
        if (cmd_req && !prev_req && cmd_reg != 5'd2 && cmd_reg != 5'd3) reg_err++;
        prev_req = cmd_req;
        if (m_done) begin
            if (cmd_ack) begin
                m_done = 1'b0;
                last_end = cyc;
            end
        end else if (cmd_req) begin
            if (lat == 0) begin
                if (cmd_reg == 5'd2) begin
                    if (passno >= wake && (int'(cmd_phy) == ph_a || int'(cmd_phy) == ph_b)) begin
                        m_data = id1_of(int'(cmd_phy));
                        hit_seen = cmd_phy;
                    end else m_data = 16'hFFFF;
                end else m_data = id2_of(int'(cmd_phy));
                m_done = 1'b1;
            end else lat--;
        end else begin
            lat = 1 + (cyc % 3);
        end
    end

    task automatic run_one(input int a, input int b, input int w, input bit restart_mid);
        int lo, t;
        bit hit;
        ph_a = a; ph_b = b; wake = w;
        passno = 0; order_err = 0; reg_err = 0; hs_err = 0;
        gap_min = 1 << 30; gap_max = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart_mid) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (!done && t < 6000) begin @(negedge clk); t++; end
        chk(done, "R9 done timeout", done, 1);
        hit = (w <= MAXP);
        lo = (b >= 0 && b < a) ? b : a;
        chk(found == hit, "R2 found", found, hit);
        chk(phy_addr == (hit ? 6'(lo) : 6'h3F), hit ? "R3 addr" : "R5 addr", phy_addr, hit ? lo : 63);
        chk(pass_count == PW'(hit ? w : MAXP), hit ? "R4 pass" : "R5 pass", pass_count, hit ? w : MAXP);
        if (hit) begin
            chk(phy_id == {id1_of(lo), id2_of(lo)}, "R3 id", phy_id, {id1_of(lo), id2_of(lo)});
            chk(model_id == ({id1_of(lo), id2_of(lo)} & 32'hFFFF_FFF0), "R7 model", model_id,
                {id1_of(lo), id2_of(lo)} & 32'hFFFF_FFF0);
        end
        chk(order_err == 0, "R1 order", order_err, 0);
        chk(reg_err == 0, "R3 reg", reg_err, 0);
        chk(hs_err == 0, "R8 handshake", hs_err, 0);
        if (passno > 1)
            chk(gap_min >= WAIT_CYC && gap_max <= WAIT_CYC + 6, "R6 gap", gap_min, WAIT_CYC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !found, "R10 flags", {done, found}, 0);
        chk(phy_addr == 6'h3F, "R10 addr", phy_addr, 63);
        chk(phy_id == 0 && pass_count == 0, "R10 id/pass", phy_id, 0);
        chk(!cmd_req && !cmd_ack, "R10 bus", {cmd_req, cmd_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 32; a++) run_one(a, -1, (a % (MAXP + 1)) + 1, 1'b0);
        run_one(20, 7, 1, 1'b0);
        run_one(3, 30, 2, 1'b0);
        run_one(12, -1, 3, 1'b1);
        begin
            logic [31:0] keep;
            keep = phy_id;
            repeat (50) @(negedge clk);
            chk(done && phy_id == keep && phy_addr == 6'd12, "R9 hold", phy_id, keep);
        end
        run_one(31, -1, MAXP + 1, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule